// File: doc/BRIEF.md
# Sequential Trie-Walk Prefix Matcher

This block resolves the longest matching prefix of a 32-bit address by walking a three-level trie in an external lookup table. The table is split 16/8/8. The top sixteen address bits index the first level directly. Each deeper level adds one further address byte to a base pointer taken from the previous table word. A word marked as a leaf ends the walk early. The word read at the third level is always the answer.

A single control state machine serves one address at a time. It issues a table read, waits for the response (the table has a fixed read latency of several cycles), and only then forms the next address. An address enters on a valid/ready input. The matched value leaves on a valid/ready output and is held there until it is taken. Results therefore come out in arrival order without any reordering logic.

The table is reached through a plain read port: a one-cycle request strobe with an address, and a response strobe with a data word. Writing the table contents is handled elsewhere.

Top module: `lpm_walker`

## Requirements
- R1: While and right after reset, `in_ready` is 1, `out_valid` is 0 and `mem_rd_en` is 0.
- R2: The first read of a walk uses the address `{0, in_addr[31:16]}` and comes in the cycle after the address is accepted. Bit 31 of a table word is the leaf flag (1 = leaf).
- R3: If the first-level word is a leaf, the walk ends after exactly one read.
- R4: A non-leaf first-level word gives a second read at `word[TBL_AW-1:0] + in_addr[15:8]`, modulo 2^TBL_AW. A leaf there ends the walk after two reads.
- R5: A non-leaf second-level word gives a third read at `word[TBL_AW-1:0] + in_addr[7:0]`, modulo 2^TBL_AW. The third word is the result whatever its leaf flag says, for exactly three reads.
- R6: At most one table read is outstanding. `mem_rd_en` is a single-cycle pulse, and it is never raised while the input is ready or a result is waiting.
- R7: `in_ready` is high only when no walk is in progress and no result is waiting. While it is low, changes on `in_valid`/`in_addr` do not affect the current walk.
- R8: `out_valid` and `out_value` hold steady until `out_ready` is seen. The cycle after the handshake, `out_valid` is 0 and `in_ready` is 1.
- R9: `out_value` equals bits [30:0] of the final table word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lookup address offered |
| in_ready | output | 1 | Matcher idle, address will be taken |
| in_addr | input | 32 | Address to match |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 31 | Matched value |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 20 | Table read address |
| mem_rd_valid | input | 1 | Table response strobe |
| mem_rd_data | input | 32 | Table response word |

## Verification
Addresses are chosen so that walks end at the first, second and third level. This tells apart the early-exit decisions and the read count of each path. A third-level word with its leaf flag clear shows that the last level is taken unconditionally. Other walks use a base pointer near the top of the table so that the sum wraps, an index byte of 0xFF, an unmapped slot, and a value with every payload bit set; these expose address-adder and field-width faults. Extra input activity while busy, a consumer that stalls, and back-to-back lookups separate correct handshake timing from a design that would take a second address early or drop a held result.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_L1,
    S_WAIT_L1,
    S_REQ_L2,
    S_WAIT_L2,
    S_REQ_L3,
    S_WAIT_L3,
    S_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    LVL_ONE,
    LVL_TWO,
    LVL_THREE
  } walk_level_e;

endpackage

// File: rtl/lpm_addr_sel.sv
module lpm_addr_sel #(
  parameter int L1_W   = 16,
  parameter int L2_W   = 8,
  parameter int L3_W   = 8,
  parameter int TBL_AW = 20
) (
  input  lpm_pkg::walk_level_e            level,
  input  logic [L1_W+L2_W+L3_W-1:0]       key,
  input  logic [TBL_AW-1:0]               base,
  output logic [TBL_AW-1:0]               addr
);
  localparam int IP_W = L1_W + L2_W + L3_W;

  logic [TBL_AW-1:0] root_idx;
  logic [TBL_AW-1:0] mid_idx;
  logic [TBL_AW-1:0] leaf_idx;

  generate
    if (TBL_AW > L1_W) begin : g_pad
      assign root_idx = {{(TBL_AW-L1_W){1'b0}}, key[IP_W-1 -: L1_W]};
    end else begin : g_exact
      assign root_idx = key[IP_W-1 -: TBL_AW];
    end
  endgenerate

  assign mid_idx  = base + TBL_AW'(key[L2_W+L3_W-1 -: L2_W]);
  assign leaf_idx = base + TBL_AW'(key[L3_W-1:0]);

  always_comb begin
    case (level)
      lpm_pkg::LVL_TWO:   addr = mid_idx;
      lpm_pkg::LVL_THREE: addr = leaf_idx;
      default:            addr = root_idx;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 out_ready,
  input  logic                 rsp_valid,
  input  logic                 rsp_leaf,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 rd_en,
  output logic                 key_ld,
  output logic                 word_ld,
  output lpm_pkg::walk_level_e level
);
  import lpm_pkg::*;

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (in_valid)  state_d = S_REQ_L1;
      S_REQ_L1:  state_d = S_WAIT_L1;
      S_WAIT_L1: if (rsp_valid) state_d = rsp_leaf ? S_DONE : S_REQ_L2;
      S_REQ_L2:  state_d = S_WAIT_L2;
      S_WAIT_L2: if (rsp_valid) state_d = rsp_leaf ? S_DONE : S_REQ_L3;
      S_REQ_L3:  state_d = S_WAIT_L3;
      S_WAIT_L3: if (rsp_valid) state_d = S_DONE;
      S_DONE:    if (out_ready) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    in_ready  = (state_q == S_IDLE);
    out_valid = (state_q == S_DONE);
    rd_en     = (state_q == S_REQ_L1) || (state_q == S_REQ_L2) ||
                (state_q == S_REQ_L3);
    key_ld    = in_ready && in_valid;
    word_ld   = rsp_valid && ((state_q == S_WAIT_L1) ||
                (state_q == S_WAIT_L2) || (state_q == S_WAIT_L3));
    case (state_q)
      S_REQ_L2: level = LVL_TWO;
      S_REQ_L3: level = LVL_THREE;
      default:  level = LVL_ONE;
    endcase
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R6

  AST_ROOT_LEAF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_L1 && rsp_valid && rsp_leaf) |=> (out_valid && !rd_en)); // R3

  AST_LAST_LEVEL_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_L3 && rsp_valid) |=> out_valid); // R5

endmodule

// File: rtl/lpm_walker.sv
module lpm_walker #(
  parameter int L1_W   = 16,
  parameter int L2_W   = 8,
  parameter int L3_W   = 8,
  parameter int WORD_W = 32,
  parameter int TBL_AW = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [L1_W+L2_W+L3_W-1:0]     in_addr,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [WORD_W-2:0]             out_value,
  output logic                          mem_rd_en,
  output logic [TBL_AW-1:0]             mem_rd_addr,
  input  logic                          mem_rd_valid,
  input  logic [WORD_W-1:0]             mem_rd_data
);
  localparam int IP_W     = L1_W + L2_W + L3_W;
  localparam int VAL_W    = WORD_W - 1;
  localparam int LEAF_BIT = WORD_W - 1;

  logic                 key_ld;
  logic                 word_ld;
  lpm_pkg::walk_level_e level;
  logic [IP_W-1:0]      key_q;
  logic [VAL_W-1:0]     word_q;

  lpm_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .rsp_valid (mem_rd_valid),
    .rsp_leaf  (mem_rd_data[LEAF_BIT]),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .rd_en     (mem_rd_en),
    .key_ld    (key_ld),
    .word_ld   (word_ld),
    .level     (level)
  );

  // Data registers carry no reset; their loads are enabled explicitly.
  always_ff @(posedge clk) begin
    if (key_ld) key_q <= in_addr;
  end

  always_ff @(posedge clk) begin
    if (word_ld) word_q <= mem_rd_data[VAL_W-1:0];
  end

  lpm_addr_sel #(
    .L1_W   (L1_W),
    .L2_W   (L2_W),
    .L3_W   (L3_W),
    .TBL_AW (TBL_AW)
  ) u_addr_sel (
    .level (level),
    .key   (key_q),
    .base  (word_q[TBL_AW-1:0]),
    .addr  (mem_rd_addr)
  );

  assign out_value = word_q;

  AST_ROOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (mem_rd_en && mem_rd_addr == TBL_AW'($past(in_addr[IP_W-1 -: L1_W])))); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value))); // R8

  AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R8

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R7

  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready || out_valid) |-> !mem_rd_en); // R6

endmodule

// File: tb/lpm_walker_tb_top.sv
`timescale 1ns/1ps
module lpm_walker_tb_top;
  localparam int TBL_AW = 20;
  localparam int LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_addr;
  logic        out_valid;
  logic        out_ready;
  logic [30:0] out_value;
  logic        mem_rd_en;
  logic [19:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  always #2.5 clk = ~clk;

  lpm_walker dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_addr      (in_addr),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_value    (out_value),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data)
  );

  // ---------------- table model (fixed latency) ----------------
  logic [31:0] tbl [int];

  function automatic logic [31:0] tbl_rd(input logic [19:0] a);
    if (tbl.exists(int'(a))) return tbl[int'(a)];
    return 32'h8000_0000;
  endfunction

  logic        pv [LAT];
  logic [31:0] pd [LAT];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
    end else begin
      pv[0] <= mem_rd_en;
      pd[0] <= tbl_rd(mem_rd_addr);
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  assign mem_rd_valid = pv[LAT-1];
  assign mem_rd_data  = pd[LAT-1];

  // ---------------- read monitor ----------------
  int          n_rd;
  int          outstanding;
  int          overlap_err;
  int          busy_ready;
  logic [19:0] rd_log [4];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_valid && outstanding > 0) outstanding--;
      if (mem_rd_en) begin
        if (outstanding != 0) overlap_err++;
        if (n_rd < 4) rd_log[n_rd] = mem_rd_addr;
        n_rd++;
        outstanding++;
      end
    end
  end

  // ---------------- checking ----------------
  int checks;
  int fails;
  bit finished;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [30:0] exp_val;
  int          exp_n;
  logic [19:0] exp_addr [3];

  task automatic ref_walk(input logic [31:0] ip);
    logic [31:0] w;
    logic [19:0] a;
    a = {4'h0, ip[31:16]};
    exp_addr[0] = a;
    w = tbl_rd(a);
    exp_n = 1;
    if (!w[31]) begin
      a = w[19:0] + {12'h0, ip[15:8]};
      exp_addr[1] = a;
      w = tbl_rd(a);
      exp_n = 2;
      if (!w[31]) begin
        a = w[19:0] + {12'h0, ip[7:0]};
        exp_addr[2] = a;
        w = tbl_rd(a);
        exp_n = 3;
      end
    end
    exp_val = w[30:0];
  endtask

  task automatic run_lookup(input logic [31:0] ip, input int hold,
                            input bit noisy, input logic [31:0] noise_ip,
                            input string tag);
    int t;
    ref_walk(ip);
    @(negedge clk);
    chk(in_ready, "R7", "ready before offer", in_ready, 1);
    in_valid    = 1'b1;
    in_addr     = ip;
    n_rd        = 0;
    overlap_err = 0;
    busy_ready  = 0;
    @(negedge clk);
    if (noisy) in_addr = noise_ip;
    else       in_valid = 1'b0;
    chk(!in_ready, "R7", "busy after accept", in_ready, 0);
    t = 0;
    while (!out_valid && t < 200) begin
      @(negedge clk);
      t++;
      if (!out_valid && in_ready) busy_ready++;
    end
    chk(out_valid, tag, "result produced", out_valid, 1);
    chk(out_value == exp_val, tag, "result value (R9)", out_value, exp_val);
    chk(n_rd == exp_n, tag, "table reads", n_rd, exp_n);
    for (int i = 0; i < 3; i++)
      if (i < exp_n)
        chk(rd_log[i] == exp_addr[i], tag, $sformatf("read address %0d", i),
            rd_log[i], exp_addr[i]);
    chk(overlap_err == 0, "R6", "one read outstanding", overlap_err, 0);
    chk(busy_ready == 0, "R7", "ready low while busy", busy_ready, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && out_value == exp_val && !in_ready, "R8",
          "result held while stalled", {out_valid, in_ready, out_value},
          {1'b1, 1'b0, exp_val});
    end
    out_ready = 1'b1;
    in_valid  = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R8", "release after handshake",
        {out_valid, in_ready}, 2'b01);
    out_ready = 1'b0;
  endtask

  task automatic build_table();
    tbl[32'h0A0B]  = 32'h8000_0123;          // root leaf
    tbl[32'h0700]  = 32'h0001_0000;          // root -> 0x10000
    tbl[32'h1000E] = 32'h8000_0456;          // level-two leaf
    tbl[32'h100FF] = 32'h8000_0099;          // level-two leaf at top byte
    tbl[32'h0A12]  = 32'h0002_0000;          // root -> 0x20000
    tbl[32'h200C8] = 32'h0003_0000;          // level two -> 0x30000
    tbl[32'h30005] = 32'h8000_0777;          // level-three leaf
    tbl[32'h30007] = 32'h0000_0042;          // level-three word, flag clear
    tbl[32'hFFFF]  = 32'h000F_FFFF;          // root -> top of table
    tbl[32'h00001] = 32'h8000_05A5;          // wrapped level-two leaf
    tbl[32'hBEEF]  = 32'hFFFF_FFFF;          // leaf with full payload
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; out_ready = 1'b0;
    n_rd = 0; outstanding = 0; overlap_err = 0; busy_ready = 0;
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !mem_rd_en, "R1", "in reset",
        {in_ready, out_valid, mem_rd_en}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !mem_rd_en, "R1", "after reset",
        {in_ready, out_valid, mem_rd_en}, 3'b100);
  endtask

  task automatic test_root_leaf();  // R2 R3
    run_lookup(32'h0A0B_1234, 0, 1'b0, '0, "R3");
    run_lookup(32'h0000_0000, 0, 1'b0, '0, "R2");  // unmapped slot
  endtask

  task automatic test_level_two();  // R4
    run_lookup(32'h0700_0E55, 0, 1'b0, '0, "R4");
    run_lookup(32'h0700_FF00, 0, 1'b0, '0, "R4");
    run_lookup(32'hFFFF_0200, 0, 1'b0, '0, "R4");  // wrap
  endtask

  task automatic test_level_three();  // R5
    run_lookup(32'h0A12_C805, 0, 1'b0, '0, "R5");
    run_lookup(32'h0A12_C807, 0, 1'b0, '0, "R5");  // flag clear, still final
  endtask

  task automatic test_full_value();  // R9
    run_lookup(32'hBEEF_0000, 0, 1'b0, '0, "R9");
  endtask

  task automatic test_busy_input();  // R7
    run_lookup(32'h0A12_C805, 0, 1'b1, 32'h0A0B_0000, "R7");
  endtask

  task automatic test_stall();  // R8
    run_lookup(32'h0700_0E00, 4, 1'b0, '0, "R8");
  endtask

  task automatic test_back_to_back();  // R6
    logic [31:0] seq [5];
    seq[0] = 32'h0A12_C807; seq[1] = 32'h0A0B_0000; seq[2] = 32'h0700_FF11;
    seq[3] = 32'hFFFF_02AA; seq[4] = 32'h0A12_C805;
    for (int i = 0; i < 5; i++) run_lookup(seq[i], i % 2, 1'b0, '0, "R6");
  endtask

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    build_table();
    test_reset();
    test_root_leaf();
    test_level_two();
    test_level_three();
    test_full_value();
    test_busy_input();
    test_stall();
    test_back_to_back();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule